// File: doc/BRIEF.md
# Sequential INT8 Fully Connected Engine

This block computes the dot products of a fully connected neural network layer over many clock cycles rather than in one wide combinational reduction. The layer has a parameterised number of output lanes, 32 by default. In each working cycle it takes one signed 8-bit activation and one weight word that holds one signed 8-bit weight per lane. Every lane multiplies the shared activation by its own weight and adds the product to its own signed accumulator. With the default 784 inputs, one pass performs 25,088 multiply-accumulates in 784 accumulate cycles.

A layer controller starts a pass with a one-cycle start pulse, then waits for the done pulse. The start pulse clears every accumulator and rewinds the input index. The engine then drives a read index that addresses both the activation source and the weight memory. The activation must arrive in the same cycle as the index. The weight word must arrive one cycle later. Inside the engine the activation is delayed by one register, so it lines up with its own weight word.

When done is pulsed, the accumulator outputs hold the finished sums. They stay stable until the next accepted start. Bias, requantization, weight error correction and the activation producer all belong to neighbouring blocks.

Top module: `fc_seq_engine`

## Requirements
- R1: After reset, busy_o, done_o and rd_en_o are 0 and every accumulator on acc_o reads 0.
- R2: A start_i sampled high while busy_o is 0 is accepted. In the next cycle busy_o is 1, rd_idx_o is 0 and every accumulator reads 0.
- R3: After an accepted start, rd_en_o is high for exactly N_IN consecutive cycles. During those cycles rd_idx_o steps through 0, 1, ..., N_IN-1 in order.
- R4: The activation on act_i belongs to the index shown in the same cycle. The weight word on wt_data_i belongs to the index shown one cycle earlier. Lane k's weight is in bits [k*8+7:k*8]. Activations and weights are signed two's complement.
- R5: At done, lane k's accumulator (acc_o bits [k*32+31:k*32]) equals the sum over all inputs i of act[i]*w[i][k]. The products are signed 16-bit values, and the sum is held in signed 32 bits that wrap on overflow.
- R6: done_o is a one-cycle pulse. It is high in the (N_IN+2)-th cycle after the edge that accepted start, and busy_o is 0 in that cycle.
- R7: While the engine is idle and no start is accepted, acc_o stays unchanged and done_o stays low.
- R8: A start_i that arrives while busy_o is 1 has no effect. The index sequence, the pass length and the final sums are the same as in a pass without it.
- R9: A start_i in the done cycle is accepted, so passes can run back to back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start pulse for one pass |
| act_i | input | 8 | Signed activation for the index on rd_idx_o, same cycle |
| wt_data_i | input | 256 | Weight word for the previous cycle's index, one signed byte per lane |
| rd_en_o | output | 1 | Read request for the activation and the weight memory |
| rd_idx_o | output | 10 | Input index used as the weight address |
| busy_o | output | 1 | A pass is in progress |
| done_o | output | 1 | One-cycle completion pulse |
| acc_o | output | 1024 | Lane accumulators, 32 signed bits per lane |

## Verification
The hardest situation to reach from the ports is the seam between one pass and the next. This covers a start that lands in the done cycle, and a stray start in the middle of a pass. In both cases the last delayed activation is still being accumulated while the control state changes. The bench places start pulses exactly on the done cycle and at a chosen mid-pass cycle. It also uses activation patterns that are nonzero only at index 0 and at the last index, so that a lost first or last accumulate changes the sums. Extreme-magnitude data, with every value at -128, checks the sign handling and the 32-bit accumulator range.

// File: rtl/fc_pkg.sv
package fc_pkg;

   // Sequencer states
   typedef enum logic [1:0] {
      SQ_IDLE  = 2'd0,
      SQ_ISSUE = 2'd1,
      SQ_DRAIN = 2'd2
   } sq_state_t;

   // Width of a signed product of two operands
   function automatic int prod_width(input int a_w, input int b_w);
      return a_w + b_w;
   endfunction

endpackage

// File: rtl/fc_seq_ctrl.sv
module fc_seq_ctrl
   import fc_pkg::*;
#(
   parameter int N_IN   = 784,
   localparam int IDX_W = (N_IN > 1) ? $clog2(N_IN) : 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start_i,
   output logic             rd_en_o,
   output logic [IDX_W-1:0] rd_idx_o,
   output logic             clr_o,
   output logic             busy_o,
   output logic             done_o
);

   localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(N_IN - 1);

   sq_state_t        state_q;
   logic [IDX_W-1:0] idx_q;
   logic             done_q;
   logic             accept;

   always_comb begin
      accept   = start_i && (state_q == SQ_IDLE);
      clr_o    = accept;
      rd_en_o  = (state_q == SQ_ISSUE);
      rd_idx_o = idx_q;
      busy_o   = (state_q != SQ_IDLE);
      done_o   = done_q;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= SQ_IDLE;
         idx_q   <= '0;
         done_q  <= 1'b0;
      end else begin
         done_q <= (state_q == SQ_DRAIN);
         unique case (state_q)
            SQ_IDLE: begin
               if (accept) begin
                  state_q <= SQ_ISSUE;
                  idx_q   <= '0;
               end
            end
            SQ_ISSUE: begin
               if (idx_q == LAST_IDX) begin
                  state_q <= SQ_DRAIN;
               end else begin
                  idx_q <= idx_q + IDX_W'(1);
               end
            end
            SQ_DRAIN: begin
               state_q <= SQ_IDLE;
            end
            default: begin
               state_q <= SQ_IDLE;
            end
         endcase
      end
   end

endmodule

// File: rtl/fc_act_stage.sv
module fc_act_stage #(
   parameter int A_W = 8
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic [A_W-1:0] act_i,
   input  logic           rd_en_i,
   output logic [A_W-1:0] act_o,
   output logic           vld_o
);

   // One stage of delay so the activation meets the weight word
   // that the memory returns one cycle after the address.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         act_o <= '0;
         vld_o <= 1'b0;
      end else begin
         vld_o <= rd_en_i;
         if (rd_en_i) begin
            act_o <= act_i;
         end
      end
   end

endmodule

// File: rtl/fc_mac_lane.sv
module fc_mac_lane
   import fc_pkg::*;
#(
   parameter int A_W   = 8,
   parameter int W_W   = 8,
   parameter int ACC_W = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr_i,
   input  logic             en_i,
   input  logic [A_W-1:0]   act_i,
   input  logic [W_W-1:0]   wt_i,
   output logic [ACC_W-1:0] acc_o
);

   localparam int P_W = prod_width(A_W, W_W);

   logic signed [P_W-1:0]   prod;
   logic signed [ACC_W-1:0] prod_ext;
   logic signed [ACC_W-1:0] acc_q;

   always_comb begin
      prod = P_W'($signed(act_i) * $signed(wt_i));
   end

   // Pick the widening path depending on the accumulator width
   generate
      if (ACC_W == P_W) begin : g_same_w
         assign prod_ext = prod;
      end else begin : g_sext
         assign prod_ext = {{(ACC_W - P_W){prod[P_W-1]}}, prod};
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         acc_q <= '0;
      end else if (clr_i) begin
         acc_q <= '0;
      end else if (en_i) begin
         acc_q <= acc_q + prod_ext;
      end
   end

   assign acc_o = acc_q;

endmodule

// File: rtl/fc_seq_engine.sv
module fc_seq_engine
   import fc_pkg::*;
#(
   parameter int N_IN   = 784,
   parameter int N_OUT  = 32,
   parameter int A_W    = 8,
   parameter int W_W    = 8,
   parameter int ACC_W  = 32,
   localparam int IDX_W = (N_IN > 1) ? $clog2(N_IN) : 1
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   start_i,
   input  logic [A_W-1:0]         act_i,
   input  logic [N_OUT*W_W-1:0]   wt_data_i,
   output logic                   rd_en_o,
   output logic [IDX_W-1:0]       rd_idx_o,
   output logic                   busy_o,
   output logic                   done_o,
   output logic [N_OUT*ACC_W-1:0] acc_o
);

   // Elaboration-time parameter checks
   generate
      if (N_IN < 2) begin : g_bad_nin
         $error("fc_seq_engine: N_IN must be at least 2");
      end
      if (N_OUT < 1) begin : g_bad_nout
         $error("fc_seq_engine: N_OUT must be at least 1");
      end
      if (A_W < 2 || W_W < 2) begin : g_bad_opw
         $error("fc_seq_engine: operand widths must be at least 2");
      end
      if (ACC_W < A_W + W_W) begin : g_bad_accw
         $error("fc_seq_engine: ACC_W narrower than the product");
      end
   endgenerate

   logic           clr;
   logic           vld_d;
   logic [A_W-1:0] act_d;

   fc_seq_ctrl #(
      .N_IN (N_IN)
   ) u_ctrl (
      .clk      (clk),
      .rst_n    (rst_n),
      .start_i  (start_i),
      .rd_en_o  (rd_en_o),
      .rd_idx_o (rd_idx_o),
      .clr_o    (clr),
      .busy_o   (busy_o),
      .done_o   (done_o)
   );

   fc_act_stage #(
      .A_W (A_W)
   ) u_act (
      .clk     (clk),
      .rst_n   (rst_n),
      .act_i   (act_i),
      .rd_en_i (rd_en_o),
      .act_o   (act_d),
      .vld_o   (vld_d)
   );

   generate
      for (genvar k = 0; k < N_OUT; k++) begin : g_lane
         fc_mac_lane #(
            .A_W   (A_W),
            .W_W   (W_W),
            .ACC_W (ACC_W)
         ) u_lane (
            .clk   (clk),
            .rst_n (rst_n),
            .clr_i (clr),
            .en_i  (vld_d),
            .act_i (act_d),
            .wt_i  (wt_data_i[k*W_W +: W_W]),
            .acc_o (acc_o[k*ACC_W +: ACC_W])
         );
      end
   endgenerate

endmodule

// File: rtl/fc_seq_engine_chk.sv
module fc_seq_engine_chk #(
   parameter int N_IN   = 784,
   parameter int N_OUT  = 32,
   parameter int ACC_W  = 32,
   localparam int IDX_W = (N_IN > 1) ? $clog2(N_IN) : 1
) (
   input logic                   clk,
   input logic                   rst_n,
   input logic                   start_i,
   input logic                   rd_en_o,
   input logic [IDX_W-1:0]       rd_idx_o,
   input logic                   busy_o,
   input logic                   done_o,
   input logic [N_OUT*ACC_W-1:0] acc_o
);

   // R2
   start_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (start_i && !busy_o) |=> (busy_o && rd_idx_o == '0 && acc_o == '0));

   // R3
   idx_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en_o && rd_idx_o != IDX_W'(N_IN - 1)) |=>
         (rd_en_o && rd_idx_o == $past(rd_idx_o) + IDX_W'(1)));

   // R3
   rd_in_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rd_en_o |-> busy_o);

   // R6
   done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o);

   // R6
   done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> (!busy_o && $past(busy_o)));

   // R7
   hold_acc_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy_o && !start_i) |=> ($stable(acc_o) && !done_o));

   // R8
   busy_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_o && start_i && !rd_en_o) |=> !busy_o);

endmodule

bind fc_seq_engine fc_seq_engine_chk #(
   .N_IN  (N_IN),
   .N_OUT (N_OUT),
   .ACC_W (ACC_W)
) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .start_i  (start_i),
   .rd_en_o  (rd_en_o),
   .rd_idx_o (rd_idx_o),
   .busy_o   (busy_o),
   .done_o   (done_o),
   .acc_o    (acc_o)
);

// File: tb/fc_seq_engine_tb_top.sv
`timescale 1ns/1ps
module fc_seq_engine_tb_top;

   localparam int N_IN  = 784;
   localparam int N_OUT = 32;
   localparam int A_W   = 8;
   localparam int W_W   = 8;
   localparam int ACC_W = 32;
   localparam int IDX_W = $clog2(N_IN);

   logic clk = 1'b0;
   always #2.5 clk = ~clk;

   logic                   rst_n;
   logic                   start_i;
   logic [A_W-1:0]         act_i;
   logic [N_OUT*W_W-1:0]   wt_data_i;
   logic                   rd_en_o;
   logic [IDX_W-1:0]       rd_idx_o;
   logic                   busy_o;
   logic                   done_o;
   logic [N_OUT*ACC_W-1:0] acc_o;

   byte act_mem [N_IN];
   byte wt_mem  [N_IN][N_OUT];

   int  total = 0;
   int  bad   = 0;
   bit  finished = 0;

   fc_seq_engine #(
      .N_IN (N_IN), .N_OUT (N_OUT), .A_W (A_W), .W_W (W_W), .ACC_W (ACC_W)
   ) dut_i (
      .clk (clk), .rst_n (rst_n), .start_i (start_i), .act_i (act_i),
      .wt_data_i (wt_data_i), .rd_en_o (rd_en_o), .rd_idx_o (rd_idx_o),
      .busy_o (busy_o), .done_o (done_o), .acc_o (acc_o)
   );

   // Activation source: same-cycle; weight memory: one cycle latency (R4)
   always_comb act_i = act_mem[int'(rd_idx_o) % N_IN];

   always @(posedge clk) begin
      if (rd_en_o) begin
         for (int k = 0; k < N_OUT; k++)
            wt_data_i[k*W_W +: W_W] <= wt_mem[int'(rd_idx_o) % N_IN][k];
      end
   end

   task automatic chk(input bit ok, input string req, input longint got, input longint exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s: got=%0d exp=%0d", req, got, exp);
      end
   endtask

   function automatic int exp_acc(input int k);
      int s = 0;
      for (int i = 0; i < N_IN; i++) s += int'(act_mem[i]) * int'(wt_mem[i][k]);
      return s;
   endfunction

   function automatic int lane_acc(input int k);
      return int'($signed(acc_o[k*ACC_W +: ACC_W]));
   endfunction

   // mode: 0 random, 1 all -128, 2 act 127 / wt -128, 3 zero acts,
   //       4 nonzero acts only at first and last index, 5 alternating signs
   task automatic fill(input int mode);
      for (int i = 0; i < N_IN; i++) begin
         case (mode)
            1: act_mem[i] = -128;
            2: act_mem[i] = 127;
            3: act_mem[i] = 0;
            4: act_mem[i] = (i == 0) ? 8'sd3 : ((i == N_IN-1) ? -8'sd7 : 8'sd0);
            5: act_mem[i] = (i % 2 == 0) ? 8'sd100 : -8'sd100;
            default: act_mem[i] = byte'($urandom);
         endcase
         for (int k = 0; k < N_OUT; k++) begin
            case (mode)
               1, 2: wt_mem[i][k] = -128;
               5:    wt_mem[i][k] = (k % 2 == 0) ? 8'sd50 : -8'sd50;
               default: wt_mem[i][k] = byte'($urandom);
            endcase
         end
      end
   endtask

   // Runs one pass; returns at the negedge of the done cycle.
   task automatic do_pass(input bit pre_started, input int ign_at, input string tag);
      int  cyc;
      int  rdn;
      bit  seq_ok;
      bit  zero_ok;
      if (!pre_started) begin
         @(negedge clk);
         start_i = 1'b1;
      end
      @(posedge clk);
      @(negedge clk);
      start_i = 1'b0;
      cyc = 1; rdn = 0; seq_ok = 1;
      // R2: cleared accumulators and index 0 right after the accepting edge
      chk(busy_o == 1'b1, {"R2 busy after start ", tag}, busy_o, 1);
      zero_ok = (acc_o == '0);
      chk(zero_ok, {"R2 accumulators cleared ", tag}, zero_ok, 1);
      chk(rd_idx_o == '0, {"R2 index rewound ", tag}, rd_idx_o, 0);
      while (1) begin
         if (done_o) break;
         if (cyc > N_IN + 8) break;
         if (rd_en_o) begin
            if (int'(rd_idx_o) != rdn) seq_ok = 0;
            rdn++;
         end
         start_i = (cyc == ign_at);
         @(negedge clk);
         cyc++;
      end
      start_i = 1'b0;
      chk(done_o == 1'b1, {"R6 done seen ", tag}, done_o, 1);
      chk(cyc == N_IN + 2, {"R6 done cycle ", tag}, cyc, N_IN + 2);
      chk(busy_o == 1'b0, {"R6 idle at done ", tag}, busy_o, 0);
      chk(rdn == N_IN, {"R3 read count ", tag}, rdn, N_IN);
      chk(seq_ok, {"R3 index order ", tag}, seq_ok, 1);
      for (int k = 0; k < N_OUT; k++)
         chk(lane_acc(k) == exp_acc(k), {"R5 R4 lane sum ", tag}, lane_acc(k), exp_acc(k));
   endtask

   task automatic idle_check(input int n, input string tag);
      logic [N_OUT*ACC_W-1:0] held;
      bit ok;
      held = acc_o;
      @(negedge clk);
      chk(done_o == 1'b0, {"R6 done one cycle ", tag}, done_o, 0);
      ok = 1;
      for (int c = 0; c < n; c++) begin
         if (acc_o != held || done_o || busy_o) ok = 0;
         @(negedge clk);
      end
      chk(ok, {"R7 outputs held while idle ", tag}, ok, 1);
   endtask

   initial begin
      #(200000 * 5);
      if (!finished) begin
         bad++;
         total++;
         $display("FAIL watchdog: got=timeout exp=completion");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd20240607));
      rst_n   = 1'b0;
      start_i = 1'b0;
      wt_data_i = '0;
      fill(3);
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1
      chk(busy_o == 1'b0, "R1 busy reset", busy_o, 0);
      chk(done_o == 1'b0, "R1 done reset", done_o, 0);
      chk(rd_en_o == 1'b0, "R1 rd_en reset", rd_en_o, 0);
      chk(acc_o == '0, "R1 acc reset", (acc_o == '0), 1);

      fill(0); do_pass(0, -1, "random");      idle_check(20, "random");
      fill(1); do_pass(0, -1, "all_min");     idle_check(5, "all_min");
      fill(2); do_pass(0, -1, "max_min");     idle_check(5, "max_min");
      fill(4); do_pass(0, -1, "edges");       idle_check(5, "edges");
      fill(3); do_pass(0, -1, "zero_act");    idle_check(5, "zero_act");
      fill(5); do_pass(0, -1, "alt_sign");    idle_check(5, "alt_sign");
      // R8: stray starts in mid-pass and in the drain cycle
      fill(0); do_pass(0, 5, "R8 mid");       idle_check(5, "R8 mid");
      fill(0); do_pass(0, N_IN + 1, "R8 drain"); idle_check(5, "R8 drain");
      // R9: back-to-back, start in the done cycle with new data
      fill(0); do_pass(0, -1, "R9 first");
      fill(4); start_i = 1'b1;
      do_pass(1, -1, "R9 second");
      fill(0); start_i = 1'b1;
      do_pass(1, -1, "R9 third");
      idle_check(10, "R9 end");

      finished = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule